// File: doc/BRIEF.md
# Coverage-Driven Lane Configuration Selector

This block sits between coverage/culling and a pool of eight combined texture-and-shading units. Each incoming 4x2 pixel tile arrives as an 8-bit live-pixel mask together with the number of texture lookups its shader needs. The block picks how the eight units are grouped for that tile: eight pixels with one unit each, four with two, two with four, or a single pixel with all eight. It then issues the surviving pixels to the unit groups over as many consecutive passes as the chosen grouping needs.

Each issued pass carries a mode code, a mask of live unit groups, and the tile pixel index that each live group must shade. Group g owns units g*U through g*U+U-1, where U is the units-per-pixel of the mode. Simple single-texture work, such as stencil fills, always keeps the full eight-wide one-unit-per-pixel grouping. Tiles where few pixels survive can spread each pixel across several units.

The selector takes a tile only while it is idle. A tile with no survivors is absorbed without producing any issue.

Top module: `lane_cfg_sel`

## Requirements
- R1: After reset no pass is issued, `busy` is low and `tileReady` is high.
- R2: A tile whose `texCount` is 0 or 1 is issued in mode 2'b00 (8 pixels x 1 unit) as a single pass, whatever its survivor count.
- R3: With `texCount` of 2 or more, the coverage part of the choice is the mode with the fewest pixel slots that still holds every survivor. Mode 2'b00 has 8 slots and covers 5 to 8 survivors. Mode 2'b01 has 4 slots and covers 3 or 4. Mode 2'b10 has 2 slots and covers 2. Mode 2'b11 has 1 slot and covers 1.
- R4: With `texCount` of 2 or more, the issued mode is never below the lookup demand mode. A count of 2 demands 2'b01, a count of 3 or 4 demands 2'b10, and a count of 5 or more demands 2'b11. The higher of the coverage mode and the demand mode is used.
- R5: Mask bit i is pixel i = y*4 + x of the tile, so row 0 is bits 0 to 3. Within a pass, live groups fill from group 0 upward with no gaps. Group k carries the k-th not-yet-issued survivor in ascending bit order. Its pixel index sits at `groupPix[3k+2:3k]`.
- R6: A tile is issued over ceil(survivors / slots) passes on consecutive cycles with an unchanged mode. `issueLast` marks the final pass.
- R7: `busy` is high from the cycle after acceptance through the last pass, and `tileReady` is its inverse. A tile offered while busy is ignored: it does not change the passes still to come and produces no issue of its own.
- R8: A tile with an all-zero mask produces no pass and leaves `busy` low.
- R9: The first pass of an accepted tile appears in the cycle right after the clock edge that accepts it.

Top module parameters: `NUM_UNITS` (8), `TILE_W` (4), `TEX_W` (4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tileValid | input | 1 | A tile is offered this cycle |
| tileMask | input | 8 | Surviving pixels of the tile, bit i = pixel y*4+x |
| texCount | input | 4 | Texture lookups needed by the shader |
| tileReady | output | 1 | The selector can accept a tile |
| busy | output | 1 | A tile is being issued |
| issueValid | output | 1 | A pass is presented this cycle |
| issueLast | output | 1 | The presented pass is the tile's last |
| issueMode | output | 2 | Grouping of the pass, log2 of units per pixel |
| groupLive | output | 8 | Group k carries a pixel |
| groupPix | output | 24 | 3-bit pixel index per group, group k at bits 3k+2:3k |

## Verification
A vector table drives each survivor count from one to eight against lookup counts of 0, 1, 2, 3 to 4 and 5 or more. This separates the single-texture override from the coverage rule, and the coverage rule from the lookup-demand floor. Sparse and scattered masks, such as alternating bits or two corner pixels, check that the group assignment follows ascending bit order and not bit position. Multi-pass tiles check the pass count, the final-pass marker and that the mode stays fixed across passes. Directed tests cover the reset state, an empty tile, and a tile offered in the middle of a long multi-pass issue.

// File: rtl/lane_cfg_pkg.sv
`timescale 1ns/1ps
package lane_cfg_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;     // capture a new tile
    logic advance;  // retire the pixels issued this cycle
  } ctrlStrobesT;
endpackage

// File: rtl/lane_cfg_dp.sv
`timescale 1ns/1ps
module lane_cfg_dp
  import lane_cfg_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int TEX_W     = 4,
  localparam int IDX_W    = $clog2(NUM_UNITS),
  localparam int MODES    = IDX_W + 1,
  localparam int MODE_W   = $clog2(MODES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobesT                    strobes,
  input  logic [NUM_UNITS-1:0]           tileMask,
  input  logic [TEX_W-1:0]               texCount,
  output logic                           anyLive,
  output logic                           lastPass,
  output logic [MODE_W-1:0]              issueMode,
  output logic [NUM_UNITS-1:0]           groupLive,
  output logic [NUM_UNITS-1:0][IDX_W-1:0] groupPix
);

  logic [NUM_UNITS-1:0] remMask;
  logic [NUM_UNITS-1:0] taken;
  logic [MODE_W-1:0]    modeQ;

  function automatic logic [MODE_W-1:0] pickMode(
    input logic [NUM_UNITS-1:0] m,
    input logic [TEX_W-1:0]     t
  );
    int live;
    int covMode;
    int demMode;
    live    = $countones(m);
    covMode = 0;
    for (int k = 0; k < MODES; k++)
      if ((NUM_UNITS >> k) >= live) covMode = k;
    demMode = MODES - 1;
    for (int k = MODES - 1; k >= 0; k--)
      if ((1 << k) >= int'(t)) demMode = k;
    if (int'(t) <= 1) return '0;
    return (covMode > demMode) ? MODE_W'(covMode) : MODE_W'(demMode);
  endfunction

  assign anyLive   = |tileMask;
  assign issueMode = modeQ;

  // Hand the lowest-indexed remaining survivors to groups 0,1,2,...
  always_comb begin
    int cnt;
    int slots;
    cnt       = 0;
    slots     = NUM_UNITS >> modeQ;
    taken     = '0;
    groupLive = '0;
    groupPix  = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (remMask[i] && cnt < slots) begin
        groupPix[cnt[IDX_W-1:0]]  = IDX_W'(i);
        groupLive[cnt[IDX_W-1:0]] = 1'b1;
        taken[i]                  = 1'b1;
        cnt                       = cnt + 1;
      end
    end
  end

  assign lastPass = (remMask & ~taken) == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remMask <= '0;
      modeQ   <= '0;
    end else if (strobes.load) begin
      remMask <= tileMask;
      modeQ   <= pickMode(tileMask, texCount);
    end else if (strobes.advance) begin
      remMask <= remMask & ~taken;
    end
  end

endmodule

// File: rtl/lane_cfg_ctrl.sv
`timescale 1ns/1ps
module lane_cfg_ctrl
  import lane_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tileValid,
  input  logic        anyLive,
  input  logic        lastPass,
  output ctrlStrobesT strobes,
  output logic        busy
);

  logic busyQ;

  always_comb begin
    strobes.load    = tileValid && !busyQ && anyLive;
    strobes.advance = busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busyQ <= 1'b0;
    else if (strobes.load) busyQ <= 1'b1;
    else if (lastPass)     busyQ <= 1'b0;
  end

  assign busy = busyQ;

endmodule

// File: rtl/lane_cfg_sel.sv
`timescale 1ns/1ps
module lane_cfg_sel
  import lane_cfg_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int TILE_W    = 4,
  parameter int TEX_W     = 4,
  localparam int TILE_H   = NUM_UNITS / TILE_W,
  localparam int IDX_W    = $clog2(TILE_W * TILE_H),
  localparam int MODE_W   = $clog2(IDX_W + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tileValid,
  input  logic [NUM_UNITS-1:0]       tileMask,
  input  logic [TEX_W-1:0]           texCount,
  output logic                       tileReady,
  output logic                       busy,
  output logic                       issueValid,
  output logic                       issueLast,
  output logic [MODE_W-1:0]          issueMode,
  output logic [NUM_UNITS-1:0]       groupLive,
  output logic [NUM_UNITS*IDX_W-1:0] groupPix
);

  ctrlStrobesT                     strobes;
  logic                            anyLive;
  logic                            lastPass;
  logic [NUM_UNITS-1:0][IDX_W-1:0] pixArr;

  lane_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tileValid(tileValid),
    .anyLive  (anyLive),
    .lastPass (lastPass),
    .strobes  (strobes),
    .busy     (busy)
  );

  lane_cfg_dp #(.NUM_UNITS(NUM_UNITS), .TEX_W(TEX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .tileMask (tileMask),
    .texCount (texCount),
    .anyLive  (anyLive),
    .lastPass (lastPass),
    .issueMode(issueMode),
    .groupLive(groupLive),
    .groupPix (pixArr)
  );

  assign tileReady  = !busy;
  assign issueValid = busy;
  assign issueLast  = busy && lastPass;
  assign groupPix   = pixArr;

endmodule

// File: rtl/lane_cfg_sel_chk.sv
`timescale 1ns/1ps
module lane_cfg_sel_chk #(
  parameter int NUM_UNITS = 8,
  parameter int TEX_W     = 4,
  parameter int MODE_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tileValid,
  input logic [NUM_UNITS-1:0] tileMask,
  input logic [TEX_W-1:0]     texCount,
  input logic                 tileReady,
  input logic                 busy,
  input logic                 issueValid,
  input logic                 issueLast,
  input logic [MODE_W-1:0]    issueMode,
  input logic [NUM_UNITS-1:0] groupLive
);

  logic accept;
  assign accept = tileValid && tileReady;

  a_r9_issue_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept && (tileMask != '0) |=> issueValid);

  a_r8_empty_no_issue: assert property (@(posedge clk) disable iff (!rstN)
    accept && (tileMask == '0) |=> !issueValid && !busy);

  a_r2_single_full: assert property (@(posedge clk) disable iff (!rstN)
    accept && (tileMask != '0) && (texCount <= 1) |=> (issueMode == '0) && issueLast);

  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueLast |=> issueValid && $stable(issueMode));

  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && issueLast |=> !busy && tileReady);

  a_r5_groups_fit: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> ($countones(groupLive) <= (NUM_UNITS >> issueMode))
                   && (groupLive != '0)
                   && (((groupLive + 1'b1) & groupLive) == '0));

endmodule

bind lane_cfg_sel lane_cfg_sel_chk #(
  .NUM_UNITS(NUM_UNITS), .TEX_W(TEX_W), .MODE_W(MODE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .tileValid(tileValid), .tileMask(tileMask),
  .texCount(texCount), .tileReady(tileReady), .busy(busy),
  .issueValid(issueValid), .issueLast(issueLast), .issueMode(issueMode),
  .groupLive(groupLive)
);

// File: tb/lane_cfg_sel_bench.sv
`timescale 1ns/1ps
module lane_cfg_sel_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tileValid = 1'b0;
  logic [7:0]  tileMask = '0;
  logic [3:0]  texCount = '0;
  logic        tileReady, busy, issueValid, issueLast;
  logic [1:0]  issueMode;
  logic [7:0]  groupLive;
  logic [23:0] groupPix;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  lane_cfg_sel u_lane_cfg_sel (
    .clk(clk), .rstN(rstN), .tileValid(tileValid), .tileMask(tileMask),
    .texCount(texCount), .tileReady(tileReady), .busy(busy),
    .issueValid(issueValid), .issueLast(issueLast), .issueMode(issueMode),
    .groupLive(groupLive), .groupPix(groupPix)
  );

  // {mask, texCount, expected mode, expected passes}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {8'hFF, 4'd1, 2'd0, 4'd1},  // R2 full tile, single texture
    {8'h5A, 4'd0, 2'd0, 4'd1},  // R2 zero lookups
    {8'h81, 4'd1, 2'd0, 4'd1},  // R2 sparse, still full width
    {8'h06, 4'd1, 2'd0, 4'd1},  // R2
    {8'h1F, 4'd2, 2'd1, 4'd2},  // R3/R4 five survivors, demand floor 01
    {8'h0F, 4'd2, 2'd1, 4'd1},  // R3 four survivors
    {8'h0B, 4'd2, 2'd1, 4'd1},  // R3 three survivors
    {8'h90, 4'd2, 2'd2, 4'd1},  // R3 two survivors
    {8'h40, 4'd2, 2'd3, 4'd1},  // R3 one survivor
    {8'h33, 4'd3, 2'd2, 4'd2},  // R4 demand 10, two passes
    {8'hFE, 4'd4, 2'd2, 4'd4},  // R4/R6 seven survivors, four passes
    {8'h70, 4'd8, 2'd3, 4'd3},  // R4 demand 11
    {8'hFF, 4'd5, 2'd3, 4'd8},  // R6 eight passes
    {8'hA5, 4'd15, 2'd3, 4'd4}, // R4 maximum count
    {8'h00, 4'd2, 2'd0, 4'd0}   // R8 empty tile
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected groups of one pass; retires the picked pixels from rem.
  task automatic expectPass(inout logic [7:0] rem, input logic [1:0] mode,
                            output logic [7:0] eLive, output logic [23:0] ePix);
    int cnt = 0;
    eLive = '0;
    ePix  = '0;
    for (int i = 0; i < 8; i++) begin
      if (rem[i] && cnt < (8 >> mode)) begin
        ePix[cnt*3 +: 3] = 3'(i);
        eLive[cnt]       = 1'b1;
        rem[i]           = 1'b0;
        cnt++;
      end
    end
  endtask

  task automatic runTile(input logic [7:0] m, input logic [3:0] t,
                         input logic [1:0] eMode, input int passes, input string tag);
    logic [7:0]  rem = m;
    logic [7:0]  eLive;
    logic [23:0] ePix;
    @(negedge clk);
    tileValid = 1'b1;
    tileMask  = m;
    texCount  = t;
    @(negedge clk);  // accepted on the edge just passed
    tileValid = 1'b0;
    for (int p = 0; p < passes; p++) begin
      expectPass(rem, eMode, eLive, ePix);
      chk(issueValid && busy, {tag, " R9/R7 pass valid"}, int'(issueValid), 1);
      chk(issueMode == eMode, {tag, " R3/R4 mode"}, int'(issueMode), int'(eMode));
      chk(issueLast == (p == passes - 1), {tag, " R6 last"}, int'(issueLast), int'(p == passes - 1));
      chk(groupLive == eLive, {tag, " R5 live"}, int'(groupLive), int'(eLive));
      chk(groupPix == ePix, {tag, " R5 pixels"}, int'(groupPix), int'(ePix));
      @(negedge clk);
    end
    chk(!issueValid && !busy && tileReady, {tag, " R6/R8 idle after"}, int'(busy), 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0]  rem;
    logic [7:0]  eLive;
    logic [23:0] ePix;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!issueValid && !busy && tileReady, "R1 reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!issueValid && !busy && tileReady, "R1 after reset", int'(issueValid), 0);

    for (int v = 0; v < NV; v++)
      runTile(VEC[v][17:10], VEC[v][9:6], VEC[v][5:4], int'(VEC[v][3:0]),
              $sformatf("vec%0d", v));

    // R7 tile offered while busy is ignored
    rem = 8'hF0;
    @(negedge clk);
    tileValid = 1'b1; tileMask = 8'hF0; texCount = 4'd9;  // mode 11, 4 passes
    @(negedge clk);
    tileMask = 8'h0F; texCount = 4'd1;                     // held while busy
    for (int p = 0; p < 4; p++) begin
      expectPass(rem, 2'd3, eLive, ePix);
      chk(!tileReady, "R7 not ready while busy", int'(tileReady), 0);
      chk(groupPix == ePix && issueMode == 2'd3, "R7 busy offer ignored",
          int'(groupPix), int'(ePix));
      if (p == 3) tileValid = 1'b0;
      @(negedge clk);
    end
    chk(!issueValid && !busy, "R7 no issue from ignored tile", int'(issueValid), 0);

    // R8 empty tile held valid for several cycles
    tileValid = 1'b1; tileMask = 8'h00; texCount = 4'd3;
    repeat (3) @(negedge clk);
    tileValid = 1'b0;
    chk(!issueValid && !busy, "R8 empty stream", int'(busy), 0);

    // R1 reset in mid issue
    runTile(8'h3C, 4'd1, 2'd0, 1, "R2 after stream");
    @(negedge clk);
    tileValid = 1'b1; tileMask = 8'hFF; texCount = 4'd8;
    @(negedge clk);
    tileValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(!issueValid && !busy && tileReady, "R1 reset mid tile", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule